// File: doc/BRIEF.md
# Two-Level Shadowed Address Translator

This block turns effective addresses into real addresses for two independent requesters: an instruction-side port and a data-side port. Each port has a private fully associative shadow table of recent translations. The hardware fills and clears the shadow tables, and software never sees them. Behind both shadows sits one shared 64-entry unified table. Software owns the unified table and writes it one entry at a time through a simple write port. Pages are a fixed 4 KB, so the low 12 address bits always pass through unchanged.

A requester raises its request with an address and holds both until it sees a one-cycle done pulse, together with the real address or a miss flag. When the mode input is low, no translation happens. When a shadow misses, the port asks the unified table for a search. The search reads four entries per cycle, starting at row 0. A hit refills the port's shadow. A miss returns a miss flag on that port only. Any write to the unified table clears both shadows, so neither shadow can hold a stale mapping.

Top module: `xlat_unit`

## Requirements
- R1: After reset, done, miss and write-acknowledge outputs are low, and both shadows and the unified table are empty: the first translated request misses after 19 cycles.
- R2: With vmode low, a request on either port completes one cycle after it is sampled, with ra equal to ea and miss low, whatever the tables hold.
- R3: With vmode high, a shadow hit completes one cycle after the request is sampled, with ra = {stored real page, ea[11:0]}. Done is a single-cycle pulse.
- R4: A shadow miss that hits unified entry index k completes k/4 + 4 cycles after the request is sampled (rows of four entries, row = index bits [5:2], searched from row 0). The returned real page is copied into that port's shadow, so the next request for that page completes in 1 cycle.
- R5: If no valid unified entry matches, the requesting port completes after 19 cycles with miss high and the other port's miss stays low. Nothing is cached, so a repeat also takes 19 cycles. An entry written with its valid input low never matches.
- R6: Each shadow holds 8 translations and refills slots in round-robin order starting at slot 0. The ninth distinct refill evicts the first page refilled.
- R7: Every unified-table write clears all entries of both shadows. This includes a refill completing in the same cycle as the write.
- R8: When both ports need the unified table at the same time, the data port is searched first. With both missing to row 2, data completes in 6 cycles and instruction in 10.
- R9: A software write waits while a unified search is in progress. The search returns the mapping that was in place before the write. sw_ack pulses for one cycle in the cycle the write takes effect, which is no earlier than the completion of the search in progress.
- R10: Any unified entry can serve either port. A 64-entry sweep alternating ports returns every mapping correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vmode | input | 1 | 1 enables translation, 0 passes addresses through |
| i_req | input | 1 | Instruction-side request, held until i_done |
| i_ea | input | 32 | Instruction-side effective address |
| i_done | output | 1 | Instruction-side completion pulse |
| i_ra | output | 32 | Instruction-side real address |
| i_miss | output | 1 | Instruction-side translation miss, valid with i_done |
| d_req | input | 1 | Data-side request, held until d_done |
| d_ea | input | 32 | Data-side effective address |
| d_done | output | 1 | Data-side completion pulse |
| d_ra | output | 32 | Data-side real address |
| d_miss | output | 1 | Data-side translation miss, valid with d_done |
| sw_we | input | 1 | Unified-table write request, held until sw_ack |
| sw_idx | input | 6 | Unified entry index to write |
| sw_valid | input | 1 | Valid bit for the written entry |
| sw_vpn | input | 20 | Virtual page number for the written entry |
| sw_rpn | input | 20 | Real page number for the written entry |
| sw_ack | output | 1 | Write-taken pulse |

## Verification
The assertions watch, on every cycle, the properties that hold locally:
- at most one shadow entry matches a page;
- a refill never duplicates a cached page;
- the unified table is written or started only while idle;
- the table owner is granted to at most one party at a time;
- a miss flag appears only with done;
- done stays a one-cycle pulse.

Only the bench scenarios can show the following:
- the exact latencies per row;
- round-robin eviction order;
- data-first ordering under simultaneous misses;
- a write that arrives mid-search still returning the old mapping, with a fresh lookup afterwards.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  // per-port sequencing state
  typedef enum logic [1:0] {
    SD_IDLE = 2'd0,
    SD_WREQ = 2'd1,
    SD_WRES = 2'd2
  } xl_side_st_e;

endpackage

// File: rtl/xlat_shadow.sv
module xlat_shadow #(
  parameter int PN_W  = 20,
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PN_W-1:0] lk_vpn,
  output logic            hit,
  output logic [PN_W-1:0] hit_rpn,
  input  logic            flush,
  input  logic            fill,
  input  logic [PN_W-1:0] fill_vpn,
  input  logic [PN_W-1:0] fill_rpn
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PN_W-1:0] vpn_r [DEPTH];
  logic [PN_W-1:0] rpn_r [DEPTH];
  logic [DEPTH-1:0] vld;
  logic [DEPTH-1:0] match;
  logic [DEPTH-1:0] fdup;
  logic [PW-1:0]    ptr;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_cmp
      assign match[g] = vld[g] && (vpn_r[g] == lk_vpn);
      assign fdup[g]  = vld[g] && (vpn_r[g] == fill_vpn);
    end
  endgenerate

  always_comb begin
    hit_rpn = '0;
    for (int i = 0; i < DEPTH; i++)
      hit_rpn = hit_rpn | (match[i] ? rpn_r[i] : '0);
  end
  assign hit = |match;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
      ptr <= '0;
    end else if (flush) begin
      vld <= '0;
    end else if (fill) begin
      vld[ptr] <= 1'b1;
      ptr <= (ptr == PW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill && !flush) begin
      vpn_r[ptr] <= fill_vpn;
      rpn_r[ptr] <= fill_rpn;
    end
  end

  // R3: a page is cached at most once
  assert_single_match_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match));
  // R6: refills only happen for pages not already cached
  assert_fill_no_dup_R6: assert property (@(posedge clk) disable iff (rst)
    fill |-> (fdup == '0));
endmodule

// File: rtl/xlat_utlb.sv
module xlat_utlb #(
  parameter int PN_W  = 20,
  parameter int DEPTH = 64,
  parameter int LANES = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_idx,
  input  logic                     wr_valid,
  input  logic [PN_W-1:0]          wr_vpn,
  input  logic [PN_W-1:0]          wr_rpn,
  input  logic                     start,
  input  logic [PN_W-1:0]          start_vpn,
  output logic                     busy,
  output logic                     done,
  output logic                     hit,
  output logic [PN_W-1:0]          rpn
);
  localparam int ROWS = DEPTH / LANES;
  localparam int RW   = $clog2(ROWS);
  localparam int LW   = $clog2(LANES);
  localparam int IW   = $clog2(DEPTH);
  localparam int EW   = 2 * PN_W;

  logic [DEPTH-1:0]            vld;
  logic [RW-1:0]               chk_row;
  logic [RW-1:0]               iss_row;
  logic [RW-1:0]               raddr;
  logic [PN_W-1:0]             key;
  logic [LANES-1:0]            lane_hit;
  logic [LANES-1:0][PN_W-1:0]  lane_rpn;
  logic                        row_hit;
  logic [PN_W-1:0]             sel_rpn;

  assign raddr = busy ? iss_row : '0;

  genvar l;
  generate
    for (l = 0; l < LANES; l++) begin : g_lane
      localparam logic [LW-1:0] LID = LW'(l);
      logic [EW-1:0] mem [ROWS];
      logic [EW-1:0] rd_q;
      always_ff @(posedge clk) begin
        if (wr_en && (wr_idx[LW-1:0] == LID))
          mem[wr_idx[IW-1:LW]] <= {wr_vpn, wr_rpn};
        rd_q <= mem[raddr];
      end
      assign lane_hit[l] = vld[{chk_row, LID}] && (rd_q[EW-1:PN_W] == key);
      assign lane_rpn[l] = rd_q[PN_W-1:0];
    end
  endgenerate

  // lowest lane wins inside a row
  always_comb begin
    sel_rpn = '0;
    for (int i = LANES - 1; i >= 0; i--)
      if (lane_hit[i]) sel_rpn = lane_rpn[i];
  end
  assign row_hit = |lane_hit;

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else if (wr_en) vld[wr_idx] <= wr_valid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      hit     <= 1'b0;
      rpn     <= '0;
      key     <= '0;
      chk_row <= '0;
      iss_row <= '0;
    end else begin
      done <= 1'b0;
      hit  <= 1'b0;
      if (start && !busy) begin
        busy    <= 1'b1;
        key     <= start_vpn;
        chk_row <= '0;
        iss_row <= RW'(1);
      end else if (busy) begin
        if (row_hit) begin
          done <= 1'b1;
          hit  <= 1'b1;
          rpn  <= sel_rpn;
          busy <= 1'b0;
        end else if (chk_row == RW'(ROWS - 1)) begin
          done <= 1'b1;
          busy <= 1'b0;
        end else begin
          chk_row <= chk_row + 1'b1;
          iss_row <= iss_row + 1'b1;
        end
      end
    end
  end

  // R9: table contents never change under a running search
  assert_write_idle_R9: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !busy);
  // R8: a new search is only launched on an idle table
  assert_start_idle_R8: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
  // R4: search completion is a single pulse
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/xlat_side.sv
module xlat_side
  import xlat_pkg::*;
#(
  parameter int AW       = 32,
  parameter int OFS_W    = 12,
  parameter int SH_DEPTH = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                vmode,
  input  logic                req,
  input  logic [AW-1:0]       ea,
  input  logic                flush,
  output logic                ureq,
  output logic [AW-OFS_W-1:0] ukey,
  input  logic                gnt,
  input  logic                u_done,
  input  logic                u_hit,
  input  logic [AW-OFS_W-1:0] u_rpn,
  output logic                done,
  output logic [AW-1:0]       ra,
  output logic                miss
);
  localparam int PN_W = AW - OFS_W;

  xl_side_st_e      st;
  logic [OFS_W-1:0] ofs_q;
  logic             sh_hit;
  logic [PN_W-1:0]  sh_rpn;
  logic             fill;

  assign ureq = (st == SD_WREQ);
  assign fill = (st == SD_WRES) && u_done && u_hit;

  xlat_shadow #(.PN_W(PN_W), .DEPTH(SH_DEPTH)) u_shadow (
    .clk      (clk),
    .rst      (rst),
    .lk_vpn   (ea[AW-1:OFS_W]),
    .hit      (sh_hit),
    .hit_rpn  (sh_rpn),
    .flush    (flush),
    .fill     (fill),
    .fill_vpn (ukey),
    .fill_rpn (u_rpn)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= SD_IDLE;
      done  <= 1'b0;
      miss  <= 1'b0;
      ra    <= '0;
      ukey  <= '0;
      ofs_q <= '0;
    end else begin
      done <= 1'b0;
      miss <= 1'b0;
      case (st)
        SD_IDLE: if (req && !done) begin
          if (!vmode) begin
            done <= 1'b1;
            ra   <= ea;
          end else if (sh_hit) begin
            done <= 1'b1;
            ra   <= {sh_rpn, ea[OFS_W-1:0]};
          end else begin
            st    <= SD_WREQ;
            ukey  <= ea[AW-1:OFS_W];
            ofs_q <= ea[OFS_W-1:0];
          end
        end
        SD_WREQ: if (gnt) st <= SD_WRES;
        SD_WRES: if (u_done) begin
          st   <= SD_IDLE;
          done <= 1'b1;
          if (u_hit) ra <= {u_rpn, ofs_q};
          else       miss <= 1'b1;
        end
        default: st <= SD_IDLE;
      endcase
    end
  end

  // R5: a miss flag only accompanies completion
  assert_miss_with_done_R5: assert property (@(posedge clk) disable iff (rst)
    miss |-> done);
  // R3: completion is a single-cycle pulse
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8: a grant only reaches a port that is asking
  assert_gnt_needs_req_R8: assert property (@(posedge clk) disable iff (rst)
    gnt |-> ureq);
endmodule

// File: rtl/xlat_unit.sv
module xlat_unit #(
  parameter int AW       = 32,
  parameter int OFS_W    = 12,
  parameter int U_DEPTH  = 64,
  parameter int U_LANES  = 4,
  parameter int SH_DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       vmode,
  input  logic                       i_req,
  input  logic [AW-1:0]              i_ea,
  output logic                       i_done,
  output logic [AW-1:0]              i_ra,
  output logic                       i_miss,
  input  logic                       d_req,
  input  logic [AW-1:0]              d_ea,
  output logic                       d_done,
  output logic [AW-1:0]              d_ra,
  output logic                       d_miss,
  input  logic                       sw_we,
  input  logic [$clog2(U_DEPTH)-1:0] sw_idx,
  input  logic                       sw_valid,
  input  logic [AW-OFS_W-1:0]        sw_vpn,
  input  logic [AW-OFS_W-1:0]        sw_rpn,
  output logic                       sw_ack
);
  localparam int PN_W = AW - OFS_W;

  logic            u_busy, u_done, u_hit;
  logic [PN_W-1:0] u_rpn;
  logic            i_ureq, d_ureq;
  logic [PN_W-1:0] i_key, d_key;
  logic            gnt_i, gnt_d, sw_go;
  logic            own_d;

  // software write first when idle, then data, then instruction
  assign sw_go = sw_we && !sw_ack && !u_busy;
  assign gnt_d = !u_busy && !sw_go && d_ureq;
  assign gnt_i = !u_busy && !sw_go && !d_ureq && i_ureq;

  always_ff @(posedge clk) begin
    if (rst) begin
      own_d  <= 1'b0;
      sw_ack <= 1'b0;
    end else begin
      sw_ack <= sw_go;
      if (gnt_d)      own_d <= 1'b1;
      else if (gnt_i) own_d <= 1'b0;
    end
  end

  xlat_utlb #(.PN_W(PN_W), .DEPTH(U_DEPTH), .LANES(U_LANES)) u_utlb (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (sw_go),
    .wr_idx    (sw_idx),
    .wr_valid  (sw_valid),
    .wr_vpn    (sw_vpn),
    .wr_rpn    (sw_rpn),
    .start     (gnt_d | gnt_i),
    .start_vpn (gnt_d ? d_key : i_key),
    .busy      (u_busy),
    .done      (u_done),
    .hit       (u_hit),
    .rpn       (u_rpn)
  );

  xlat_side #(.AW(AW), .OFS_W(OFS_W), .SH_DEPTH(SH_DEPTH)) u_iside (
    .clk    (clk),
    .rst    (rst),
    .vmode  (vmode),
    .req    (i_req),
    .ea     (i_ea),
    .flush  (sw_go),
    .ureq   (i_ureq),
    .ukey   (i_key),
    .gnt    (gnt_i),
    .u_done (u_done && !own_d),
    .u_hit  (u_hit),
    .u_rpn  (u_rpn),
    .done   (i_done),
    .ra     (i_ra),
    .miss   (i_miss)
  );

  xlat_side #(.AW(AW), .OFS_W(OFS_W), .SH_DEPTH(SH_DEPTH)) u_dside (
    .clk    (clk),
    .rst    (rst),
    .vmode  (vmode),
    .req    (d_req),
    .ea     (d_ea),
    .flush  (sw_go),
    .ureq   (d_ureq),
    .ukey   (d_key),
    .gnt    (gnt_d),
    .u_done (u_done && own_d),
    .u_hit  (u_hit),
    .u_rpn  (u_rpn),
    .done   (d_done),
    .ra     (d_ra),
    .miss   (d_miss)
  );

  // R8: the unified table has a single owner per cycle
  assert_one_owner_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({gnt_d, gnt_i, sw_go}));
endmodule

// File: tb/tb_xlat_unit.sv
`timescale 1ns/1ps
module tb_xlat_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        vmode = 1'b0;
  logic        i_req = 1'b0, d_req = 1'b0;
  logic [31:0] i_ea = '0, d_ea = '0;
  logic        i_done, d_done, i_miss, d_miss;
  logic [31:0] i_ra, d_ra;
  logic        sw_we = 1'b0, sw_valid = 1'b0;
  logic [5:0]  sw_idx = '0;
  logic [19:0] sw_vpn = '0, sw_rpn = '0;
  logic        sw_ack;

  int checks = 0, fails = 0, cyc = 0;

  xlat_unit dut (
    .clk(clk), .rst(rst), .vmode(vmode),
    .i_req(i_req), .i_ea(i_ea), .i_done(i_done), .i_ra(i_ra), .i_miss(i_miss),
    .d_req(d_req), .d_ea(d_ea), .d_done(d_done), .d_ra(d_ra), .d_miss(d_miss),
    .sw_we(sw_we), .sw_idx(sw_idx), .sw_valid(sw_valid),
    .sw_vpn(sw_vpn), .sw_rpn(sw_rpn), .sw_ack(sw_ack)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) if (cyc == 60000) begin
    fails++;
    $display("FAIL watchdog expired act=%0d exp<60000", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
    $finish;
  end

  function automatic logic [19:0] vpn_of(int k); return 20'h40000 + 20'(k * 97); endfunction
  function automatic logic [19:0] rpn_of(int k); return 20'h0A003 + 20'(k * 613); endfunction
  function automatic logic [11:0] off_of(int k); return 12'(k * 53 + 7); endfunction
  function automatic logic [31:0] ea_of(int k); return {vpn_of(k), off_of(k)}; endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  task automatic xlat(input bit dside, input logic [31:0] ea, output int lat,
                      output logic [31:0] ra, output bit mis, output bit other_mis,
                      output int dcyc);
    bit got = 0;
    @(negedge clk);
    if (dside) begin d_req = 1; d_ea = ea; end else begin i_req = 1; i_ea = ea; end
    lat = 0; ra = '0; mis = 0; other_mis = 0; dcyc = 0;
    while (!got && lat < 200) begin
      @(negedge clk);
      lat++;
      if (dside ? d_done : i_done) begin
        got = 1;
        ra = dside ? d_ra : i_ra;
        mis = dside ? d_miss : i_miss;
        other_mis = dside ? i_miss : d_miss;
        dcyc = cyc;
        if (dside) d_req = 0; else i_req = 0;
      end
    end
    if (dside) d_req = 0; else i_req = 0;
  endtask

  task automatic sw_write(input int idx, input bit v, input logic [19:0] vp,
                          input logic [19:0] rp, output int acyc);
    int n = 0;
    @(negedge clk);
    sw_we = 1; sw_idx = 6'(idx); sw_valid = v; sw_vpn = vp; sw_rpn = rp;
    acyc = 0;
    while (n < 200) begin
      @(negedge clk);
      n++;
      if (sw_ack) begin acyc = cyc; n = 1000; end
    end
    sw_we = 0;
  endtask

  // translate and check latency, address and miss flag
  task automatic tr(input string rq, input bit dside, input logic [31:0] ea,
                    input int exp_lat, input logic [31:0] exp_ra, input bit exp_mis);
    int lat, dc; logic [31:0] ra; bit mis, om;
    xlat(dside, ea, lat, ra, mis, om, dc);
    chk(lat == exp_lat, rq, "latency", lat, exp_lat);
    chk(mis == exp_mis, rq, "miss", mis, exp_mis);
    if (!exp_mis) chk(ra == exp_ra, rq, "real address", ra, exp_ra);
  endtask

  initial begin
    int ac, lat, dc, lat2, dc2;
    logic [31:0] ra, ra2;
    bit mis, om, mis2, om2;
    logic [31:0] bp [6];
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk(!i_done && !d_done && !i_miss && !d_miss && !sw_ack, "R1", "outputs after reset",
        {i_done, d_done, i_miss, d_miss, sw_ack}, 0);
    vmode = 1;
    xlat(0, 32'h1234_5678, lat, ra, mis, om, dc);
    chk(lat == 19 && mis, "R1", "empty tables miss", lat, 19);

    // R2: bypass on both ports
    vmode = 0;
    bp[0] = 32'h0; bp[1] = 32'hFFFF_FFFF; bp[2] = ea_of(5);
    bp[3] = 32'h8000_0001; bp[4] = 32'h0000_0FFF; bp[5] = 32'hDEAD_BEEF;
    for (int j = 0; j < 6; j++) begin
      tr("R2", 0, bp[j], 1, bp[j], 0);
      tr("R2", 1, bp[j] ^ 32'h5A5A_0000, 1, bp[j] ^ 32'h5A5A_0000, 0);
    end
    vmode = 1;

    // fill the unified table
    for (int k = 0; k < 64; k++) sw_write(k, 1, vpn_of(k), rpn_of(k), ac);

    // R4 and R10: sweep, alternating ports
    for (int k = 0; k < 64; k++)
      tr("R4_R10", k[0], ea_of(k), k / 4 + 4, {rpn_of(k), off_of(k)}, 0);

    // R3: shadow hit on data port, new offset
    tr("R3", 1, {vpn_of(63), 12'hABC}, 1, {rpn_of(63), 12'hABC}, 0);
    @(negedge clk);
    chk(!d_done, "R3", "done is a pulse", d_done, 0);
    // R10: instruction port uses the same entry via the unified table
    tr("R10", 0, ea_of(63), 19, {rpn_of(63), off_of(63)}, 0);
    // R2: bypass ignores cached entries
    vmode = 0;
    tr("R2", 1, ea_of(63), 1, ea_of(63), 0);
    vmode = 1;

    // R6: round robin; a rewrite of entry 63 flushes both shadows first
    sw_write(63, 1, vpn_of(63), rpn_of(63), ac);
    for (int k = 0; k < 9; k++)
      tr("R6", 1, ea_of(k), k / 4 + 4, {rpn_of(k), off_of(k)}, 0);
    tr("R6", 1, ea_of(1), 1, {rpn_of(1), off_of(1)}, 0);
    tr("R6", 1, ea_of(0), 4, {rpn_of(0), off_of(0)}, 0);
    tr("R6", 1, ea_of(1), 4, {rpn_of(1), off_of(1)}, 0);

    // R7: write flushes both shadows
    tr("R7", 0, ea_of(2), 4, {rpn_of(2), off_of(2)}, 0);
    tr("R7", 0, ea_of(2), 1, {rpn_of(2), off_of(2)}, 0);
    tr("R7", 1, ea_of(0), 1, {rpn_of(0), off_of(0)}, 0);
    sw_write(40, 1, vpn_of(40), rpn_of(40), ac);
    tr("R7", 0, ea_of(2), 4, {rpn_of(2), off_of(2)}, 0);
    tr("R7", 1, ea_of(0), 4, {rpn_of(0), off_of(0)}, 0);

    // R5: miss, side specific, not cached, invalidated entry
    xlat(1, 32'hFFFF_F123, lat, ra, mis, om, dc);
    chk(lat == 19 && mis, "R5", "data miss", lat, 19);
    chk(!om, "R5", "instruction miss stays low", om, 0);
    tr("R5", 1, 32'hFFFF_F123, 19, 32'h0, 1);
    sw_write(5, 0, vpn_of(5), rpn_of(5), ac);
    xlat(0, ea_of(5), lat, ra, mis, om, dc);
    chk(lat == 19 && mis, "R5", "invalid entry misses", lat, 19);
    chk(!om, "R5", "data miss stays low", om, 0);

    // R8: simultaneous misses to row 2
    sw_write(40, 1, vpn_of(40), rpn_of(40), ac);
    fork
      xlat(0, ea_of(8), lat, ra, mis, om, dc);
      xlat(1, ea_of(9), lat2, ra2, mis2, om2, dc2);
    join
    chk(lat2 == 6, "R8", "data first latency", lat2, 6);
    chk(lat == 10, "R8", "instruction waits", lat, 10);
    chk(ra == {rpn_of(8), off_of(8)} && ra2 == {rpn_of(9), off_of(9)}, "R8", "addresses",
        ra, {rpn_of(8), off_of(8)});

    // R9: write arriving mid-search waits and the search sees the old map
    fork
      xlat(0, ea_of(60), lat, ra, mis, om, dc);
      begin repeat (3) @(negedge clk); sw_write(60, 1, vpn_of(60), 20'h77777, ac); end
    join
    chk(lat == 19 && ra == {rpn_of(60), off_of(60)}, "R9", "old mapping returned",
        ra, {rpn_of(60), off_of(60)});
    chk(ac >= dc, "R9", "ack not before search end", ac, dc);
    tr("R9", 0, ea_of(60), 19, {20'h77777, off_of(60)}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule